// File: doc/BRIEF.md
# Direction-Grouped Row-Hit-First Request Scheduler

This block holds pending memory requests for a set of banks and, for one bank at a time, names the request that should be issued next. Every bank owns two queues, one for reads and one for writes. An incoming request goes to the queue of its bank and direction. Requests leave when the issuing logic removes them by tag, naming the bank and direction the tag was enqueued with.

Selection follows the direction of the most recently removed request. That direction's queue is searched first, and the other queue is used only when the preferred one is empty. Inside the searched queue, a request whose row matches the open row of an active bank wins, oldest first. If no entry matches, or the bank is idle, the oldest entry wins. Two hints, each qualified by a direction, tell the bank logic whether more work of that direction is waiting and whether a second request to a given row is waiting. The bank logic uses these hints to decide whether to keep a row open.

Selection and hints are combinational from the queue state and the query inputs. Enqueue, removal and the direction register update on the rising clock edge.

Top module: `dgs_sched`

## Requirements
- R1: A request with `enq_write`=0 is stored only in the read queue of bank `enq_bank`, and one with `enq_write`=1 only in that bank's write queue. No other bank's selection changes.
- R2: When the last removed direction is read (`sel_write`=0 encoding), a non-empty read queue of bank `sel_bank` is selected. Otherwise a non-empty write queue is selected. With both queues empty, `sel_valid` is 0.
- R3: When the last removed direction is write, the write queue is searched first and the read queue second.
- R4: Within the searched queue, with `sel_active`=1 the oldest entry whose row equals `sel_open_row` is returned (`sel_tag`, `sel_row`). With no such entry, or with `sel_active`=0, the oldest entry is returned.
- R5: The last-direction state is read after reset. Every removal sets it to `rem_write`, whether or not the tag is found.
- R6: `hint_more_req` is 1 exactly when the queue of bank `hint_bank` and direction `hint_write` holds two or more entries.
- R7: `hint_more_hit` is 1 exactly when that same queue holds two or more entries whose row equals `hint_row`. The other direction's entries are not counted.
- R8: A removal deletes the oldest entry with tag `rem_tag` from the queue of bank `rem_bank` and direction `rem_write` only, and keeps the age order of the remaining entries. A tag absent from that queue leaves all queues unchanged.
- R9: An enqueue into a queue that already holds `QDEPTH` entries is discarded, and the stored entries are kept.
- R10: After reset all queues are empty, so `sel_valid`, `hint_more_req` and `hint_more_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store a request this cycle |
| enq_bank | input | BANK_W | Target bank of the stored request |
| enq_write | input | 1 | Direction of the stored request, 1 = write |
| enq_row | input | ROW_W | Row of the stored request |
| enq_tag | input | TAG_W | Tag of the stored request |
| rem_valid | input | 1 | Remove a request this cycle |
| rem_bank | input | BANK_W | Bank of the request to remove |
| rem_write | input | 1 | Direction of the request to remove, 1 = write |
| rem_tag | input | TAG_W | Tag of the request to remove |
| sel_bank | input | BANK_W | Bank being queried for its next request |
| sel_active | input | 1 | Queried bank has a row open |
| sel_open_row | input | ROW_W | Row open in the queried bank |
| sel_valid | output | 1 | A request was found for the queried bank |
| sel_write | output | 1 | Direction of the found request |
| sel_tag | output | TAG_W | Tag of the found request |
| sel_row | output | ROW_W | Row of the found request |
| hint_bank | input | BANK_W | Bank probed by the hints |
| hint_write | input | 1 | Direction probed by the hints |
| hint_row | input | ROW_W | Row probed by the row-hit hint |
| hint_more_req | output | 1 | Probed queue holds at least two entries |
| hint_more_hit | output | 1 | Probed queue holds at least two entries on `hint_row` |

## Verification
The assertions assume that query and probe inputs are stable around the rising edge. They also assume that a removal and an enqueue aimed at the same queue never arrive in the same cycle, so the direction and occupancy relations are judged on a settled state. The tags within one queue are assumed unique, so a removal names exactly one entry. The stimulus drives every input on the falling edge, spends one cycle per operation, and never reuses a tag that is still present in the queue it targets.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

   // Direction encoding shared by the queues, the selection logic and the checker.
   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;

   // Width of an occupancy counter able to hold 0..depth.
   function automatic int occ_width(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/dgs_queue.sv
// Age-ordered request queue: index 0 is always the oldest entry.
// Removal by tag closes the gap by shifting younger entries down.
module dgs_queue #(
   parameter int DEPTH = 4,
   parameter int ROW_W = 8,
   parameter int TAG_W = 4,
   localparam int CNT_W = dgs_pkg::occ_width(DEPTH),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push_en,
   input  logic [ROW_W-1:0]       push_row,
   input  logic [TAG_W-1:0]       push_tag,
   input  logic                   pull_en,
   input  logic [TAG_W-1:0]       pull_tag,
   output logic [CNT_W-1:0]       occ_o,
   output logic [DEPTH*ROW_W-1:0] rows_o,
   output logic [DEPTH*TAG_W-1:0] tags_o
);

   logic [ROW_W-1:0] row_q [DEPTH];
   logic [ROW_W-1:0] row_d [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TAG_W-1:0] tag_d [DEPTH];
   logic [CNT_W-1:0] occ_q, occ_mid, occ_d;

   logic             match_found;
   logic [IDX_W-1:0] match_idx;

   // Oldest live entry carrying the tag to pull.
   always_comb begin
      match_found = 1'b0;
      match_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if ((CNT_W'(i) < occ_q) && (tag_q[i] == pull_tag)) begin
            match_found = 1'b1;
            match_idx   = IDX_W'(i);
         end
      end
   end

   // Removal first (shift down), then append behind the survivors.
   always_comb begin
      row_d   = row_q;
      tag_d   = tag_q;
      occ_mid = occ_q;
      if (pull_en && match_found) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (IDX_W'(i) >= match_idx) begin
               row_d[i] = row_q[i+1];
               tag_d[i] = tag_q[i+1];
            end
         end
         occ_mid = occ_q - 1'b1;
      end
      occ_d = occ_mid;
      if (push_en && (occ_mid < CNT_W'(DEPTH))) begin
         row_d[occ_mid[IDX_W-1:0]] = push_row;
         tag_d[occ_mid[IDX_W-1:0]] = push_tag;
         occ_d = occ_mid + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            row_q[i] <= '0;
            tag_q[i] <= '0;
         end
      end else begin
         occ_q <= occ_d;
         row_q <= row_d;
         tag_q <= tag_d;
      end
   end

   assign occ_o = occ_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_flat
      assign rows_o[i*ROW_W +: ROW_W] = row_q[i];
      assign tags_o[i*TAG_W +: TAG_W] = tag_q[i];
   end

endmodule

// File: rtl/dgs_pick.sv
// Row-hit-first, then oldest, choice inside one age-ordered queue.
module dgs_pick #(
   parameter int DEPTH = 4,
   parameter int ROW_W = 8,
   parameter int TAG_W = 4,
   localparam int CNT_W = dgs_pkg::occ_width(DEPTH),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [CNT_W-1:0]       occ_i,
   input  logic [DEPTH*ROW_W-1:0] rows_i,
   input  logic [DEPTH*TAG_W-1:0] tags_i,
   input  logic                   active_i,
   input  logic [ROW_W-1:0]       open_row_i,
   output logic                   pick_vld_o,
   output logic [ROW_W-1:0]       pick_row_o,
   output logic [TAG_W-1:0]       pick_tag_o
);

   logic [IDX_W-1:0] win_idx;

   // Lowest index is oldest; scanning downward leaves the oldest hit.
   always_comb begin
      win_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (active_i && (CNT_W'(i) < occ_i) &&
             (rows_i[i*ROW_W +: ROW_W] == open_row_i)) begin
            win_idx = IDX_W'(i);
         end
      end
   end

   assign pick_vld_o = (occ_i != '0);
   assign pick_row_o = rows_i[win_idx*ROW_W +: ROW_W];
   assign pick_tag_o = tags_i[win_idx*TAG_W +: TAG_W];

endmodule

// File: rtl/dgs_hint.sv
// Look-ahead hints over one queue: more work waiting, more work on a row.
module dgs_hint #(
   parameter int DEPTH = 4,
   parameter int ROW_W = 8,
   localparam int CNT_W = dgs_pkg::occ_width(DEPTH)
) (
   input  logic [CNT_W-1:0]       occ_i,
   input  logic [DEPTH*ROW_W-1:0] rows_i,
   input  logic [ROW_W-1:0]       probe_row_i,
   output logic                   more_req_o,
   output logic                   more_hit_o
);

   logic [CNT_W-1:0] hits;

   always_comb begin
      hits = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if ((CNT_W'(i) < occ_i) && (rows_i[i*ROW_W +: ROW_W] == probe_row_i)) begin
            hits = hits + 1'b1;
         end
      end
   end

   assign more_req_o = (occ_i >= CNT_W'(2));
   assign more_hit_o = (hits  >= CNT_W'(2));

endmodule

// File: rtl/dgs_sched.sv
// Per-bank read/write queues with direction-sticky, row-hit-first selection.
module dgs_sched #(
   parameter int NUM_BANKS = 4,
   parameter int QDEPTH    = 4,
   parameter int ROW_W     = 8,
   parameter int TAG_W     = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int CNT_W    = dgs_pkg::occ_width(QDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [BANK_W-1:0] enq_bank,
   input  logic              enq_write,
   input  logic [ROW_W-1:0]  enq_row,
   input  logic [TAG_W-1:0]  enq_tag,
   input  logic              rem_valid,
   input  logic [BANK_W-1:0] rem_bank,
   input  logic              rem_write,
   input  logic [TAG_W-1:0]  rem_tag,
   input  logic [BANK_W-1:0] sel_bank,
   input  logic              sel_active,
   input  logic [ROW_W-1:0]  sel_open_row,
   output logic              sel_valid,
   output logic              sel_write,
   output logic [TAG_W-1:0]  sel_tag,
   output logic [ROW_W-1:0]  sel_row,
   input  logic [BANK_W-1:0] hint_bank,
   input  logic              hint_write,
   input  logic [ROW_W-1:0]  hint_row,
   output logic              hint_more_req,
   output logic              hint_more_hit
);

   import dgs_pkg::*;

   // Elaboration-time parameter checks.
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("dgs_sched: NUM_BANKS must be at least 2");
   end
   if (QDEPTH < 2) begin : g_bad_depth
      $error("dgs_sched: QDEPTH must be at least 2");
   end
   if ((ROW_W < 1) || (TAG_W < 1)) begin : g_bad_width
      $error("dgs_sched: ROW_W and TAG_W must be positive");
   end

   logic [CNT_W-1:0]        occ  [NUM_BANKS][2];
   logic [QDEPTH*ROW_W-1:0] rows [NUM_BANKS][2];
   logic [QDEPTH*TAG_W-1:0] tags [NUM_BANKS][2];
   logic [NUM_BANKS*2*CNT_W-1:0] occ_flat;

   dir_e last_dir_q;

   // One queue per bank and direction; index 0 = read, 1 = write.
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar d = 0; d < 2; d++) begin : g_dir
         dgs_queue #(
            .DEPTH (QDEPTH),
            .ROW_W (ROW_W),
            .TAG_W (TAG_W)
         ) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_en  (enq_valid && (enq_bank == BANK_W'(b)) && (enq_write == 1'(d))),
            .push_row (enq_row),
            .push_tag (enq_tag),
            .pull_en  (rem_valid && (rem_bank == BANK_W'(b)) && (rem_write == 1'(d))),
            .pull_tag (rem_tag),
            .occ_o    (occ[b][d]),
            .rows_o   (rows[b][d]),
            .tags_o   (tags[b][d])
         );
         assign occ_flat[(b*2+d)*CNT_W +: CNT_W] = occ[b][d];
      end
   end

   // Candidate from each direction of the queried bank.
   logic             pk_vld [2];
   logic [ROW_W-1:0] pk_row [2];
   logic [TAG_W-1:0] pk_tag [2];

   for (genvar d = 0; d < 2; d++) begin : g_pick
      dgs_pick #(
         .DEPTH (QDEPTH),
         .ROW_W (ROW_W),
         .TAG_W (TAG_W)
      ) u_pick (
         .occ_i      (occ[sel_bank][d]),
         .rows_i     (rows[sel_bank][d]),
         .tags_i     (tags[sel_bank][d]),
         .active_i   (sel_active),
         .open_row_i (sel_open_row),
         .pick_vld_o (pk_vld[d]),
         .pick_row_o (pk_row[d]),
         .pick_tag_o (pk_tag[d])
      );
   end

   // Stay with the last issued direction while it has work in the bank.
   logic pref, alt;

   always_comb begin
      pref      = (last_dir_q == DIR_WR);
      alt       = ~pref;
      sel_valid = 1'b0;
      sel_write = 1'b0;
      sel_tag   = '0;
      sel_row   = '0;
      if (pk_vld[pref]) begin
         sel_valid = 1'b1;
         sel_write = pref;
         sel_tag   = pk_tag[pref];
         sel_row   = pk_row[pref];
      end else if (pk_vld[alt]) begin
         sel_valid = 1'b1;
         sel_write = alt;
         sel_tag   = pk_tag[alt];
         sel_row   = pk_row[alt];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_dir_q <= DIR_RD;
      end else if (rem_valid) begin
         last_dir_q <= dir_e'(rem_write);
      end
   end

   dgs_hint #(
      .DEPTH (QDEPTH),
      .ROW_W (ROW_W)
   ) u_hint (
      .occ_i       (occ[hint_bank][hint_write]),
      .rows_i      (rows[hint_bank][hint_write]),
      .probe_row_i (hint_row),
      .more_req_o  (hint_more_req),
      .more_hit_o  (hint_more_hit)
   );

endmodule

// File: rtl/dgs_sched_chk.sv
module dgs_sched_chk #(
   parameter int NUM_BANKS = 4,
   parameter int QDEPTH    = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int CNT_W    = dgs_pkg::occ_width(QDEPTH)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         rem_valid,
   input logic                         rem_write,
   input logic [BANK_W-1:0]            sel_bank,
   input logic                         sel_valid,
   input logic                         sel_write,
   input logic                         hint_more_req,
   input logic                         hint_more_hit,
   input logic                         last_wr,
   input logic [NUM_BANKS*2*CNT_W-1:0] occ_flat
);

   logic [CNT_W-1:0] rd_occ, wr_occ;
   logic             any_over;

   always_comb begin
      rd_occ   = occ_flat[(int'(sel_bank)*2)*CNT_W +: CNT_W];
      wr_occ   = occ_flat[(int'(sel_bank)*2+1)*CNT_W +: CNT_W];
      any_over = 1'b0;
      for (int i = 0; i < NUM_BANKS*2; i++) begin
         if (occ_flat[i*CNT_W +: CNT_W] > CNT_W'(QDEPTH)) any_over = 1'b1;
      end
   end

   // R2
   rd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!last_wr && (rd_occ != '0)) |-> (sel_valid && !sel_write));

   // R3
   wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_wr && (wr_occ != '0)) |-> (sel_valid && sel_write));

   // R2
   empty_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_occ == '0) && (wr_occ == '0)) |-> !sel_valid);

   // R5
   last_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_valid |=> (last_wr == $past(rem_write)));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_over);

   // R7
   hint_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hint_more_hit |-> hint_more_req);

endmodule

bind dgs_sched dgs_sched_chk #(
   .NUM_BANKS (NUM_BANKS),
   .QDEPTH    (QDEPTH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rem_valid     (rem_valid),
   .rem_write     (rem_write),
   .sel_bank      (sel_bank),
   .sel_valid     (sel_valid),
   .sel_write     (sel_write),
   .hint_more_req (hint_more_req),
   .hint_more_hit (hint_more_hit),
   .last_wr       (last_dir_q),
   .occ_flat      (occ_flat)
);

// File: tb/dgs_sched_test.sv
`timescale 1ns/1ps
module dgs_sched_test;

   localparam logic [1:0] OP_ENQ = 2'd0;
   localparam logic [1:0] OP_REM = 2'd1;
   localparam logic [1:0] OP_CHK = 2'd2;

   typedef struct packed {
      logic [1:0] op;
      logic [1:0] bank;
      logic       wr;
      logic [7:0] row;   // enqueue row, or open row for a check
      logic [3:0] tag;
      logic       act;
      logic       ev;
      logic       ew;
      logic [3:0] et;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{OP_ENQ, 2'd0, 1'b0, 8'd5, 4'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},  // R1
      '{OP_ENQ, 2'd0, 1'b1, 8'd5, 4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},  // R1
      '{OP_CHK, 2'd0, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd5},  // R5 reset dir = read
      '{OP_ENQ, 2'd0, 1'b0, 8'd7, 4'd3, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},
      '{OP_CHK, 2'd0, 1'b0, 8'd7, 4'd0, 1'b1, 1'b1, 1'b0, 4'd3, 4'd4},  // R4 row hit
      '{OP_CHK, 2'd0, 1'b0, 8'd7, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd4},  // R4 idle bank
      '{OP_CHK, 2'd0, 1'b0, 8'd9, 4'd0, 1'b1, 1'b1, 1'b0, 4'd1, 4'd4},  // R4 no hit
      '{OP_REM, 2'd0, 1'b1, 8'd0, 4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},
      '{OP_CHK, 2'd0, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd3},  // R3 fallback to reads
      '{OP_ENQ, 2'd0, 1'b1, 8'd7, 4'd4, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},
      '{OP_CHK, 2'd0, 1'b0, 8'd5, 4'd0, 1'b1, 1'b1, 1'b1, 4'd4, 4'd3},  // R3 writes first
      '{OP_REM, 2'd0, 1'b0, 8'd0, 4'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},
      '{OP_CHK, 2'd0, 1'b0, 8'd5, 4'd0, 1'b1, 1'b1, 1'b0, 4'd3, 4'd2},  // R2 reads first
      '{OP_REM, 2'd0, 1'b0, 8'd0, 4'd3, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},
      '{OP_CHK, 2'd0, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd4, 4'd2},  // R2 fallback to writes
      '{OP_REM, 2'd0, 1'b1, 8'd0, 4'd4, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},
      '{OP_CHK, 2'd0, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd2},  // R2 both empty
      '{OP_ENQ, 2'd1, 1'b1, 8'd3, 4'd5, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},
      '{OP_CHK, 2'd0, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1},  // R1 other bank untouched
      '{OP_CHK, 2'd1, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd5, 4'd1},  // R1 stored as write
      '{OP_REM, 2'd1, 1'b0, 8'd0, 4'd5, 1'b0, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 wrong queue
      '{OP_CHK, 2'd1, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd5, 4'd8},  // R8 entry survives
      '{OP_REM, 2'd1, 1'b1, 8'd0, 4'd5, 1'b0, 1'b0, 1'b0, 4'd0, 4'd8},
      '{OP_CHK, 2'd1, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd8}   // R8 removed
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enq_valid = 1'b0;
   logic [1:0] enq_bank = '0;
   logic       enq_write = 1'b0;
   logic [7:0] enq_row = '0;
   logic [3:0] enq_tag = '0;
   logic       rem_valid = 1'b0;
   logic [1:0] rem_bank = '0;
   logic       rem_write = 1'b0;
   logic [3:0] rem_tag = '0;
   logic [1:0] sel_bank = '0;
   logic       sel_active = 1'b0;
   logic [7:0] sel_open_row = '0;
   logic       sel_valid, sel_write;
   logic [3:0] sel_tag;
   logic [7:0] sel_row;
   logic [1:0] hint_bank = '0;
   logic       hint_write = 1'b0;
   logic [7:0] hint_row = '0;
   logic       hint_more_req, hint_more_hit;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;  // 250 MHz

   dgs_sched uut (
      .clk (clk), .rst_n (rst_n),
      .enq_valid (enq_valid), .enq_bank (enq_bank), .enq_write (enq_write),
      .enq_row (enq_row), .enq_tag (enq_tag),
      .rem_valid (rem_valid), .rem_bank (rem_bank), .rem_write (rem_write),
      .rem_tag (rem_tag),
      .sel_bank (sel_bank), .sel_active (sel_active), .sel_open_row (sel_open_row),
      .sel_valid (sel_valid), .sel_write (sel_write), .sel_tag (sel_tag),
      .sel_row (sel_row),
      .hint_bank (hint_bank), .hint_write (hint_write), .hint_row (hint_row),
      .hint_more_req (hint_more_req), .hint_more_hit (hint_more_hit)
   );

   task automatic enq(input int b, input bit w, input int row, input int tag);
      @(negedge clk);
      enq_valid = 1'b1; enq_bank = b[1:0]; enq_write = w;
      enq_row = row[7:0]; enq_tag = tag[3:0];
      @(posedge clk); #1;
      enq_valid = 1'b0;
   endtask

   task automatic rem(input int b, input bit w, input int tag);
      @(negedge clk);
      rem_valid = 1'b1; rem_bank = b[1:0]; rem_write = w; rem_tag = tag[3:0];
      @(posedge clk); #1;
      rem_valid = 1'b0;
   endtask

   task automatic chk_sel(input int req, input int b, input bit act, input int row,
                          input bit ev, input bit ew, input int et);
      @(negedge clk);
      sel_bank = b[1:0]; sel_active = act; sel_open_row = row[7:0];
      #1;
      checks++;
      if ((sel_valid !== ev) || (ev && ((sel_write !== ew) || (sel_tag !== et[3:0])))) begin
         errors++;
         $display("FAIL R%0d: bank %0d got valid=%0b write=%0b tag=%0d, expected valid=%0b write=%0b tag=%0d",
                  req, b, sel_valid, sel_write, sel_tag, ev, ew, et);
      end
   endtask

   task automatic chk_hint(input int req, input int b, input bit w, input int row,
                           input bit er, input bit eh);
      @(negedge clk);
      hint_bank = b[1:0]; hint_write = w; hint_row = row[7:0];
      #1;
      checks++;
      if ((hint_more_req !== er) || (hint_more_hit !== eh)) begin
         errors++;
         $display("FAIL R%0d: hint bank %0d dir %0b row %0d got req=%0b hit=%0b, expected req=%0b hit=%0b",
                  req, b, w, row, hint_more_req, hint_more_hit, er, eh);
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      chk_sel(10, 0, 1'b0, 0, 1'b0, 1'b0, 0);
      chk_hint(10, 0, 1'b0, 0, 1'b0, 1'b0);

      // Table walk: R1 R2 R3 R4 R5 R8
      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            OP_ENQ:  enq(int'(VEC[i].bank), VEC[i].wr, int'(VEC[i].row), int'(VEC[i].tag));
            OP_REM:  rem(int'(VEC[i].bank), VEC[i].wr, int'(VEC[i].tag));
            default: chk_sel(int'(VEC[i].req), int'(VEC[i].bank), VEC[i].act,
                             int'(VEC[i].row), VEC[i].ev, VEC[i].ew, int'(VEC[i].et));
         endcase
      end

      // R4 oldest of several row hits, with its row reported
      enq(2, 1'b0, 4, 9);
      enq(2, 1'b0, 6, 10);
      enq(2, 1'b0, 6, 11);
      chk_sel(4, 2, 1'b1, 6, 1'b1, 1'b0, 10);
      checks++;
      if (sel_row !== 8'd6) begin
         errors++;
         $display("FAIL R4: sel_row got %0d, expected 6", sel_row);
      end

      // R6 R7 hints, direction-qualified
      chk_hint(7, 2, 1'b0, 6, 1'b1, 1'b1);
      chk_hint(7, 2, 1'b0, 4, 1'b1, 1'b0);
      enq(2, 1'b1, 6, 12);
      chk_hint(6, 2, 1'b1, 6, 1'b0, 1'b0);
      chk_hint(6, 2, 1'b0, 9, 1'b1, 1'b0);
      enq(2, 1'b1, 6, 13);
      chk_hint(7, 2, 1'b1, 6, 1'b1, 1'b1);

      // R9 fifth enqueue into a full read queue is discarded
      for (int t = 1; t <= 5; t++) enq(3, 1'b0, t, t);
      chk_sel(9, 3, 1'b0, 0, 1'b1, 1'b0, 1);
      rem(3, 1'b0, 1);
      chk_sel(9, 3, 1'b0, 0, 1'b1, 1'b0, 2);
      rem(3, 1'b0, 2);
      chk_sel(9, 3, 1'b0, 0, 1'b1, 1'b0, 3);
      rem(3, 1'b0, 3);
      chk_sel(9, 3, 1'b0, 0, 1'b1, 1'b0, 4);
      rem(3, 1'b0, 4);
      chk_sel(9, 3, 1'b0, 0, 1'b0, 1'b0, 0);

      // R8 removal from the middle keeps age order
      enq(3, 1'b0, 0, 6);
      enq(3, 1'b0, 0, 7);
      enq(3, 1'b0, 0, 8);
      rem(3, 1'b0, 7);
      chk_sel(8, 3, 1'b0, 0, 1'b1, 1'b0, 6);
      rem(3, 1'b0, 6);
      chk_sel(8, 3, 1'b0, 0, 1'b1, 1'b0, 8);
      chk_hint(6, 3, 1'b0, 0, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule